// File: doc/BRIEF.md
# DDR2 Bank Command Sequencer

This block turns one internal memory request at a time into the DDR2 SDRAM command sequence that serves it. It remembers, for every bank, whether a row is open and which row that is. From that state it works out whether the request needs a precharge, an activate, or only the column command. It drives the chip-select, RAS, CAS, WE, bank-select and address pins, and it keeps every command inside a set of programmable minimum spacings counted in memory clock cycles. Each spacing input holds the required number of cycles minus one.

Requests arrive on a valid/ready channel carrying bank, row, column and direction. The requester raises `req_valid` and holds every request field stable until it sees `req_ready` high at a rising edge. `req_ready` is high only in the cycle in which the block picks the read or write column command for that request. The handshake is therefore the command-issued strobe: once the handshake completes, the request counts as accepted. The requester may keep `req_valid` high for any number of cycles, and holding it back costs nothing beyond delay. After reset the block closes all banks with an all-bank precharge before it accepts anything. The spacing inputs are expected to change only while reset is asserted.

Top module: `ddr2_cmd_seq`

## Requirements
- R1: While reset is asserted the pins show deselect (all four control pins high, bank and address zero) and `req_ready` is low. In the first cycle after reset is released, the pins carry an all-bank precharge (address bit 10 high, rest of address and bank zero). No request is accepted before that cycle.
- R2: `req_ready` is high only in a cycle in which the column command for the presented request is chosen. That column command appears on the pins in the cycle after the accepting edge.
- R3: The pins (cs_n, ras_n, cas_n, we_n) encode commands as follows: activate 0011, read 0101, write 0100, precharge (single or all) 0010, refresh 0001, mode register set 0000, no-op 0111. Idle cycles drive deselect 1111.
- R4: A request whose bank holds the requested row open gets a read (`req_write`=0) or write (`req_write`=1) command. The bank pins carry the bank and the address carries the column zero-extended, so address bit 10 is low.
- R5: A request to a closed bank first gets an activate command with the bank on the bank pins and the row on the address.
- R6: A request to a bank with a different row open first gets a single-bank precharge with address bit 10 low (whole address zero) and the bank on the bank pins, then an activate, then the column command.
- R7: An activate and the next read or write to the same bank are at least `cfg_trcd_m1`+1 cycles apart.
- R8: A precharge (single to that bank, or all-bank) and the next activate to the same bank are at least `cfg_trp_m1`+1 cycles apart.
- R9: An activate and the next single-bank precharge to the same bank are at least `cfg_tras_m1`+1 cycles apart.
- R10: Two activate commands are at least `cfg_trrd_m1`+1 cycles apart.
- R11: Every command appears in the earliest cycle the rules allow. That cycle is the latest of: the cycle after the request was first presented, the cycle after the previous command, and the limits of R7 to R10. No command appears without a pending request or the initial precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd_m1 | input | TIMER_W | Activate to read/write spacing, minus one |
| cfg_trp_m1 | input | TIMER_W | Precharge to activate spacing, minus one |
| cfg_tras_m1 | input | TIMER_W | Activate to precharge spacing, minus one |
| cfg_trrd_m1 | input | TIMER_W | Activate to activate spacing, minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted; column command chosen this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BANK_W | Bank select |
| ddr_addr | output | ADDR_W | Row/column address; bit 10 selects all-bank precharge |

## Verification
Command choice is combinational in the cycle a request is presented. The pins are registered, so any command shows up one cycle after the decision, and the first possible pin cycle for a request presented in cycle s is s+1. The all-bank precharge is due exactly one cycle after reset release. A column command is due exactly one cycle after the cycle in which `req_ready` was seen high. The bench samples on the falling edge and keeps its own model of open rows and of the earliest cycle each command kind is allowed per bank. For every command it predicts the exact cycle, kind, bank and address, and it also checks each minimum spacing on its own, across a sweep of spacing settings and request patterns.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

  typedef enum logic [2:0] {
    C_NONE,
    C_ACT,
    C_RD,
    C_WR,
    C_PRE,
    C_PREA,
    C_REF,
    C_MRS
  } seq_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_code_t;

  function automatic pin_code_t seq_encode(seq_cmd_e c);
    pin_code_t p;
    case (c)
      C_ACT:   p = 4'b0011;
      C_RD:    p = 4'b0101;
      C_WR:    p = 4'b0100;
      C_PRE:   p = 4'b0010;
      C_PREA:  p = 4'b0010;
      C_REF:   p = 4'b0001;
      C_MRS:   p = 4'b0000;
      default: p = 4'b1111;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track
  import ddr2_seq_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int TIMER_W = 4,
  localparam int NB     = 1 << BANK_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  seq_cmd_e                 issue,
  input  logic [BANK_W-1:0]        issue_bank,
  input  logic [ROW_W-1:0]         issue_row,
  input  logic [TIMER_W-1:0]       cfg_trcd_m1,
  input  logic [TIMER_W-1:0]       cfg_trp_m1,
  input  logic [TIMER_W-1:0]       cfg_tras_m1,
  input  logic [TIMER_W-1:0]       cfg_trrd_m1,
  output logic [NB-1:0]            open_o,
  output logic [NB-1:0][ROW_W-1:0] row_o,
  output logic [NB-1:0]            rdy_o,
  output logic [NB-1:0]            ras_ok_o,
  output logic                     rrd_ok_o
);

  logic [TIMER_W-1:0] rrd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rrd_q <= '0;
    else if (issue == C_ACT) rrd_q <= cfg_trrd_m1;
    else if (rrd_q != '0) rrd_q <= rrd_q - TIMER_W'(1);
  end
  assign rrd_ok_o = (rrd_q == '0);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic               open_q;
    logic [ROW_W-1:0]   row_q;
    logic [TIMER_W-1:0] gate_q;
    logic [TIMER_W-1:0] ras_q;
    logic               hit;

    assign hit = (issue_bank == BANK_W'(g));

    // gate_q counts tRP while closed and tRCD while open
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
        gate_q <= '0;
      end else if (issue == C_PREA) begin
        open_q <= 1'b0;
        gate_q <= cfg_trp_m1;
      end else if (hit && issue == C_ACT) begin
        open_q <= 1'b1;
        row_q  <= issue_row;
        gate_q <= cfg_trcd_m1;
      end else if (hit && issue == C_PRE) begin
        open_q <= 1'b0;
        gate_q <= cfg_trp_m1;
      end else if (gate_q != '0) begin
        gate_q <= gate_q - TIMER_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ras_q <= '0;
      else if (hit && issue == C_ACT) ras_q <= cfg_tras_m1;
      else if (ras_q != '0) ras_q <= ras_q - TIMER_W'(1);
    end

    assign open_o[g]   = open_q;
    assign row_o[g]    = row_q;
    assign rdy_o[g]    = (gate_q == '0);
    assign ras_ok_o[g] = (ras_q == '0);

    // R8
    prea_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue == C_PREA) |=> !open_q);
  end

  // R10
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue == C_ACT && cfg_trrd_m1 != '0) |=> !rrd_ok_o);

endmodule

// File: rtl/ddr2_cmd_pick.sv
module ddr2_cmd_pick
  import ddr2_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int NB    = 1 << BANK_W
) (
  input  logic                     init_pending,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [NB-1:0]            open_i,
  input  logic [NB-1:0][ROW_W-1:0] row_i,
  input  logic [NB-1:0]            rdy_i,
  input  logic [NB-1:0]            ras_ok_i,
  input  logic                     rrd_ok_i,
  output seq_cmd_e                 cmd,
  output logic                     ready
);

  logic sel_open, sel_hit, sel_rdy, sel_ras;

  assign sel_open = open_i[req_bank];
  assign sel_hit  = (row_i[req_bank] == req_row);
  assign sel_rdy  = rdy_i[req_bank];
  assign sel_ras  = ras_ok_i[req_bank];

  always_comb begin
    cmd   = C_NONE;
    ready = 1'b0;
    if (init_pending) begin
      cmd = C_PREA;
    end else if (req_valid) begin
      if (!sel_open) begin
        if (sel_rdy && rrd_ok_i) cmd = C_ACT;
      end else if (sel_hit) begin
        if (sel_rdy) begin
          cmd   = req_write ? C_WR : C_RD;
          ready = 1'b1;
        end
      end else if (sel_ras) begin
        cmd = C_PRE;
      end
    end
  end

endmodule

// File: rtl/ddr2_pin_drive.sv
module ddr2_pin_drive
  import ddr2_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  localparam int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cmd_e          cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);

  pin_code_t         code;
  logic [ADDR_W-1:0] addr_d;
  logic [BANK_W-1:0] ba_d;

  always_comb begin
    code   = seq_encode(cmd);
    addr_d = '0;
    ba_d   = '0;
    case (cmd)
      C_ACT:       begin addr_d = ADDR_W'(row); ba_d = bank; end
      C_RD, C_WR:  begin addr_d = ADDR_W'(col); ba_d = bank; end
      C_PRE:       ba_d = bank;
      C_PREA:      addr_d[AP_BIT] = 1'b1;
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba   <= '0;
      addr <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= code;
      ba   <= ba_d;
      addr <= addr_d;
    end
  end

  // R4
  col_ap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |=> (!cs_n && ras_n && !addr[AP_BIT]));

endmodule

// File: rtl/ddr2_cmd_seq.sv
module ddr2_cmd_seq
  import ddr2_seq_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int ADDR_W  = 14,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int TIMER_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] cfg_trcd_m1,
  input  logic [TIMER_W-1:0] cfg_trp_m1,
  input  logic [TIMER_W-1:0] cfg_tras_m1,
  input  logic [TIMER_W-1:0] cfg_trrd_m1,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [COL_W-1:0]   req_col,
  output logic               ddr_cs_n,
  output logic               ddr_ras_n,
  output logic               ddr_cas_n,
  output logic               ddr_we_n,
  output logic [BANK_W-1:0]  ddr_ba,
  output logic [ADDR_W-1:0]  ddr_addr
);

  localparam int NB = 1 << BANK_W;

  seq_cmd_e                 pick_cmd;
  logic                     pick_ready;
  logic                     init_pending;
  logic [NB-1:0]            bank_open;
  logic [NB-1:0][ROW_W-1:0] bank_row;
  logic [NB-1:0]            bank_rdy;
  logic [NB-1:0]            bank_ras_ok;
  logic                     rrd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) init_pending <= 1'b1;
    else if (pick_cmd == C_PREA) init_pending <= 1'b0;
  end

  ddr2_bank_track #(.BANK_W(BANK_W), .ROW_W(ROW_W), .TIMER_W(TIMER_W)) u_track (
    .clk(clk), .rst_n(rst_n), .issue(pick_cmd), .issue_bank(req_bank),
    .issue_row(req_row), .cfg_trcd_m1(cfg_trcd_m1), .cfg_trp_m1(cfg_trp_m1),
    .cfg_tras_m1(cfg_tras_m1), .cfg_trrd_m1(cfg_trrd_m1),
    .open_o(bank_open), .row_o(bank_row), .rdy_o(bank_rdy),
    .ras_ok_o(bank_ras_ok), .rrd_ok_o(rrd_ok)
  );

  ddr2_cmd_pick #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_pick (
    .init_pending(init_pending), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .open_i(bank_open),
    .row_i(bank_row), .rdy_i(bank_rdy), .ras_ok_i(bank_ras_ok),
    .rrd_ok_i(rrd_ok), .cmd(pick_cmd), .ready(pick_ready)
  );

  ddr2_pin_drive #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .cmd(pick_cmd), .bank(req_bank), .row(req_row),
    .col(req_col), .cs_n(ddr_cs_n), .ras_n(ddr_ras_n), .cas_n(ddr_cas_n),
    .we_n(ddr_we_n), .ba(ddr_ba), .addr(ddr_addr)
  );

  assign req_ready = pick_ready;

  // R1
  no_accept_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pending |-> !req_ready);

  // R2
  ready_with_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pick_cmd == C_RD || pick_cmd == C_WR));

  // R4
  column_row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_cmd == C_RD || pick_cmd == C_WR) |->
      (bank_open[req_bank] && bank_row[req_bank] == req_row));

  // R5
  act_bank_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_cmd == C_ACT) |-> (!bank_open[req_bank] && rrd_ok));

  // R9
  pre_after_tras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_cmd == C_PRE) |-> (bank_open[req_bank] && bank_ras_ok[req_bank]));

endmodule

// File: tb/ddr2_cmd_seq_test.sv
module ddr2_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_trcd_m1 = '0, cfg_trp_m1 = '0, cfg_tras_m1 = '0, cfg_trrd_m1 = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [2:0]  ddr_ba;
  logic [13:0] ddr_addr;

  ddr2_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_trcd_m1(cfg_trcd_m1), .cfg_trp_m1(cfg_trp_m1),
    .cfg_tras_m1(cfg_tras_m1), .cfg_trrd_m1(cfg_trrd_m1), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n),
    .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;

  // command kinds: 0 none, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PREA, 9 other code
  bit m_open [8];
  int m_row [8];
  int act_ok [8], col_ok [8], pre_ok [8], last_act [8], last_pre [8];
  int any_act_ok, last_act_any, last_pin, rel_cyc, acc_cyc;
  bit init_wait, pend, late_flag;
  int p_bank, p_row, p_col, p_start;
  bit p_wr;
  int trcd, trp, tras, trrd;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic predict(output int ek, output int ec, output int eb, output int ea);
    if (init_wait) begin
      ek = 5; ec = rel_cyc + 1; eb = 0; ea = 1024;
    end else begin
      eb = p_bank;
      if (!m_open[p_bank]) begin
        ek = 1; ec = imax(act_ok[p_bank], any_act_ok); ea = p_row;
      end else if (m_row[p_bank] == p_row) begin
        ek = p_wr ? 3 : 2; ec = col_ok[p_bank]; ea = p_col;
      end else begin
        ek = 4; ec = pre_ok[p_bank]; ea = 0;
      end
      ec = imax(ec, imax(p_start + 1, last_pin + 1));
    end
  endtask

  task automatic observe();
    int k, ek, ec, eb, ea, c;
    string tg;
    c = cyc;
    if (ddr_cs_n) k = 0;
    else case ({ddr_ras_n, ddr_cas_n, ddr_we_n})
      3'b011: k = 1;
      3'b101: k = 2;
      3'b100: k = 3;
      3'b010: k = ddr_addr[10] ? 5 : 4;
      default: k = 9;
    endcase
    if (!(init_wait || pend)) begin
      if (k != 0) chk(1'b0, "R11 command without pending request", k, 0);
      return;
    end
    predict(ek, ec, eb, ea);
    if (k == 0) begin
      if (c >= ec && !late_flag) begin
        chk(1'b0, "R11 command missing at due cycle", c, ec);
        late_flag = 1'b1;
      end
      return;
    end
    late_flag = 1'b0;
    case (ek)
      1: tg = "R5 activate";
      2, 3: tg = "R4 column";
      4: tg = "R6 precharge";
      default: tg = "R1 all-bank precharge";
    endcase
    chk(k == ek, {"R3 command code for ", tg}, k, ek);
    chk(c == ec, {"R11 issue cycle of ", tg}, c, ec);
    chk(int'(ddr_ba) == eb, {tg, " bank"}, int'(ddr_ba), eb);
    chk(int'(ddr_addr) == ea, {tg, " address"}, int'(ddr_addr), ea);
    case (ek)
      5: begin
        for (int i = 0; i < 8; i++) begin
          m_open[i] = 1'b0; act_ok[i] = c + trp + 1; last_pre[i] = c;
        end
        init_wait = 1'b0;
      end
      1: begin
        chk(c - last_pre[eb] >= trp + 1, "R8 precharge to activate gap", c - last_pre[eb], trp + 1);
        chk(c - last_act_any >= trrd + 1, "R10 activate to activate gap", c - last_act_any, trrd + 1);
        m_open[eb] = 1'b1; m_row[eb] = p_row;
        col_ok[eb] = c + trcd + 1; pre_ok[eb] = c + tras + 1;
        any_act_ok = c + trrd + 1; last_act[eb] = c; last_act_any = c;
      end
      4: begin
        chk(c - last_act[eb] >= tras + 1, "R9 activate to precharge gap", c - last_act[eb], tras + 1);
        m_open[eb] = 1'b0; act_ok[eb] = c + trp + 1; last_pre[eb] = c;
      end
      default: begin
        chk(c - last_act[eb] >= trcd + 1, "R7 activate to column gap", c - last_act[eb], trcd + 1);
        chk(c == acc_cyc + 1, "R2 column one cycle after handshake", c, acc_cyc + 1);
        pend = 1'b0;
      end
    endcase
    last_pin = c;
  endtask

  task automatic step();
    @(negedge clk);
    observe();
  endtask

  task automatic send(input int b, input int r, input int c, input bit w);
    int ek, ec, eb, ea;
    req_bank = 3'(b); req_row = 14'(r); req_col = 10'(c); req_write = w;
    req_valid = 1'b1;
    p_bank = b; p_row = r; p_col = c; p_wr = w; p_start = cyc; pend = 1'b1;
    for (int n = 0; ; n++) begin
      #1;
      if (req_ready) begin
        predict(ek, ec, eb, ea);
        chk(ek == 2 || ek == 3, "R2 ready only with column command", ek, w ? 3 : 2);
        acc_cyc = cyc;
        step();
        req_valid = 1'b0;
        break;
      end
      if (n > 300) begin
        chk(1'b0, "R11 request never accepted", n, 0);
        req_valid = 1'b0; pend = 1'b0;
        break;
      end
      step();
    end
  endtask

  task automatic run_config(input int i);
    trcd = i % 4; trp = (i + 2) % 4; tras = (i * 5) % 8; trrd = (i / 2) % 4;
    cfg_trcd_m1 = 4'(trcd); cfg_trp_m1 = 4'(trp);
    cfg_tras_m1 = 4'(tras); cfg_trrd_m1 = 4'(trrd);
    rst_n = 1'b0; req_valid = 1'b0; pend = 1'b0; init_wait = 1'b0; late_flag = 1'b0;
    for (int j = 0; j < 8; j++) begin
      m_open[j] = 1'b0; m_row[j] = 0; act_ok[j] = 0; col_ok[j] = 0; pre_ok[j] = 0;
      last_act[j] = -1000; last_pre[j] = -1000;
    end
    any_act_ok = 0; last_act_any = -1000; last_pin = -1000;
    for (int j = 0; j < 3; j++) begin
      step();
      #1;
      // R1 reset state
      chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
      chk({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b1111 && ddr_addr == 0,
          "R1 deselect in reset", {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, 15);
    end
    rst_n = 1'b1; rel_cyc = cyc; init_wait = 1'b1;
    send(0, 5, 3, 1'b0);
    send(0, 5, 7, 1'b1);
    send(0, 9, 1, 1'b0);
    send(1, 9, 2, 1'b1);
    repeat (i % 3) step();
    send(2, 1, 4, 1'b0);
    send(1, 2, 5, 1'b0);
    send(7, 16383, 1023, 1'b1);
    send(0, 9, 0, 1'b0);
    for (int k = 0; k < 14; k++) begin
      send((k * 5) % 8, k % 3, (k * 37) % 1024, k[0]);
      if (k % 4 == 3) repeat (2) step();
    end
    repeat (4) step();
    chk(!pend && !init_wait, "R11 all requests served", pend, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) run_config(i);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11 watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule